// File: doc/BRIEF.md
# Flash Access Protection Controller

This block sits between a processor bus and an on-chip flash array of 128 KB. It accepts one request per cycle: a data read, an instruction fetch, a word program or a 1-KB block erase. It checks each request against a protection table and then drives a simple word-wide memory port toward the array. Reads come back on a pipelined response path. Programs are a read-modify-write that can only clear bits. An erase walks every word of one 1-KB block and writes all ones.

Protection is held per 2-KB region, which is two adjacent erase blocks, so the array has 64 regions. A region is open, read-only or execute-only. In the execute-only mode only a processor instruction fetch may read the region. A data read, any debug-port read, a program and an erase are all refused. Any refused request raises a one-cycle error pulse. Region modes are set through a small write port. At run time a mode can only be tightened, and only a reset relaxes it.

The array is external. The memory port has registered read data: a word addressed while `mem_re` is high appears on `mem_rdata` in the next cycle. A write takes effect at the clock edge that ends the cycle in which `mem_we` is high.

Top module: `flash_guard`

## Requirements
- R1: A read (`req_op` 00) or fetch (`req_op` 01) to an open region is accepted in cycle T. It returns the stored word at byte address bits [16:2] with `rsp_valid` high in cycle T+3.
- R2: An erase (`req_op` 11) to an open region sets all 256 words of the 1-KB block selected by address bits [16:10] to FFFFFFFF. Words in other blocks are left unchanged.
- R3: A program (`req_op` 10) to an open region stores the bitwise AND of the old word and `req_wdata`. A later program therefore never sets a bit back to 1.
- R4: An accepted program holds `busy` high for exactly PROG_CYC cycles, starting in the cycle after acceptance. An accepted erase holds it for 256+ERASE_TAIL cycles. `req_ready` is the inverse of `busy`, and a request presented while `busy` is high waits until `busy` falls.
- R5: The region of a request is address bits [16:11]. The region mode codes are 00 open, 01 read-only, 10 execute-only, and 11 behaves as execute-only.
- R6: In a read-only region, a program or erase leaves the array unchanged, does not raise `busy`, and pulses `acc_err` in the cycle after acceptance. Reads and fetches in that region succeed.
- R7: In an execute-only region, only a fetch with `req_dbg` low returns data. A data read, or any request with `req_dbg` high, returns zero with `rsp_valid` and `acc_err` both high in cycle T+3.
- R8: In an execute-only region, a program or erase is refused as in R6.
- R9: A mode write through `prot_we` takes effect from the next cycle, and only if it tightens the region (open < read-only < execute-only). A write that would relax the region is ignored.
- R10: Reset clears every region to open and drives `busy`, `rsp_valid` and `acc_err` low.
- R11: Each refused request produces its own one-cycle `acc_err` pulse. Two refused writes accepted in back-to-back cycles give two consecutive high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 00 read, 01 fetch, 10 program, 11 erase |
| req_dbg | input | 1 | Request comes from the debug port |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 32 | Program data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data, zero when refused |
| acc_err | output | 1 | Refused-access pulse |
| busy | output | 1 | Program or erase in progress |
| prot_we | input | 1 | Region mode write strobe |
| prot_region | input | 6 | Region index for the mode write |
| prot_mode | input | 2 | New mode code |
| mem_re | output | 1 | Array read strobe |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 15 | Array word address |
| mem_wdata | output | 32 | Array write data |
| mem_rdata | input | 32 | Array read data, one cycle after `mem_re` |

## Verification
A corrupted protection entry shows up at the first later request to that region. The symptom is a missing or extra `acc_err` pulse, or a zeroed `rsp_rdata`, three cycles after a read or one cycle after a program or erase. A wrong busy count shows up on the first cycle that `busy` differs from its fixed window. A wrong read-modify-write or erase walk leaves bad array contents. Those show only when the affected word is read again, so every program and erase in the bench is followed by reads of the target word and of words in the neighbouring blocks. The reference model follows every cycle, so each difference is caught in the cycle it first reaches a port.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_FETCH = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } fg_op_e;

  localparam logic [1:0] MODE_OPEN  = 2'b00;
  localparam logic [1:0] MODE_RONLY = 2'b01;
  localparam logic [1:0] MODE_XONLY = 2'b10;

  // strictness order: open 0, read-only 1, execute-only (10 or 11) 2
  function automatic logic [1:0] fg_rank(input logic [1:0] m);
    case (m)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] fg_norm(input logic [1:0] m);
    return (m == 2'b11) ? MODE_XONLY : m;
  endfunction

endpackage

// File: rtl/fg_region_table.sv
module fg_region_table
  import fg_pkg::*;
#(
  parameter int NREG   = 64,
  parameter int RIDX_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_en,
  input  logic [RIDX_W-1:0]   upd_idx,
  input  logic [1:0]          upd_mode,
  input  logic [RIDX_W-1:0]   look_idx,
  output logic [1:0]          look_mode,
  output logic [2*NREG-1:0]   tbl_flat
);

  logic [NREG-1:0][1:0] tbl;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[g] <= MODE_OPEN;
      end else if (upd_en && (upd_idx == RIDX_W'(g)) &&
                   (fg_rank(upd_mode) > fg_rank(tbl[g]))) begin
        tbl[g] <= fg_norm(upd_mode);
      end
    end
    assign tbl_flat[2*g +: 2] = tbl[g];
  end

  assign look_mode = tbl[look_idx];

endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import fg_pkg::*;
(
  input  logic [1:0] op,
  input  logic       dbg,
  input  logic [1:0] mode,
  output logic       allow
);

  logic [1:0] rank;
  assign rank = fg_rank(mode);

  always_comb begin
    case (op)
      OP_READ:  allow = (rank != 2'd2);
      OP_FETCH: allow = (rank != 2'd2) || !dbg;
      default:  allow = (rank == 2'd0);
    endcase
  end

endmodule

// File: rtl/fg_read_pipe.sv
module fg_read_pipe #(
  parameter int WA_W = 15,
  parameter int DW   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             allow,
  input  logic [WA_W-1:0]  waddr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             re,
  output logic [WA_W-1:0]  raddr,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rd_err
);

  logic s1_v, s1_blk, s2_v, s2_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_blk    <= 1'b0;
      s2_v      <= 1'b0;
      s2_blk    <= 1'b0;
      re        <= 1'b0;
      raddr     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rd_err    <= 1'b0;
    end else begin
      s1_v      <= issue;
      s1_blk    <= issue & ~allow;
      re        <= issue & allow;
      if (issue) raddr <= waddr;
      s2_v      <= s1_v;
      s2_blk    <= s1_blk;
      rsp_valid <= s2_v;
      rsp_data  <= (s2_v && !s2_blk) ? mem_rdata : '0;
      rd_err    <= s2_v & s2_blk;
    end
  end

endmodule

// File: rtl/fg_write_engine.sv
module fg_write_engine #(
  parameter int WA_W       = 15,
  parameter int DW         = 32,
  parameter int BLK_WORDS  = 256,
  parameter int PROG_CYC   = 6,
  parameter int ERASE_TAIL = 4,
  localparam int BI_W      = $clog2(BLK_WORDS),
  localparam int ERASE_DUR = BLK_WORDS + ERASE_TAIL,
  localparam int MAX_DUR   = (ERASE_DUR > PROG_CYC) ? ERASE_DUR : PROG_CYC,
  localparam int CNT_W     = $clog2(MAX_DUR + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_erase,
  input  logic [WA_W-1:0]  waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             re,
  output logic             we,
  output logic [WA_W-1:0]  addr,
  output logic [DW-1:0]    wdata_o
);

  typedef enum logic [2:0] {W_IDLE, W_PRD, W_PCAP, W_PWR, W_ERASE} wst_e;

  wst_e             st;
  logic [CNT_W-1:0] cnt;
  logic [BI_W-1:0]  idx;
  logic [DW-1:0]    wd_hold;

  // fixed-length busy window, independent of the sequencing below
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= is_erase ? CNT_W'(ERASE_DUR - 1) : CNT_W'(PROG_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      re      <= 1'b0;
      we      <= 1'b0;
      addr    <= '0;
      wdata_o <= '0;
      wd_hold <= '0;
      idx     <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (start && is_erase) begin
            we      <= 1'b1;
            addr    <= {waddr[WA_W-1:BI_W], {BI_W{1'b0}}};
            wdata_o <= '1;
            idx     <= '0;
            st      <= W_ERASE;
          end else if (start) begin
            re      <= 1'b1;
            addr    <= waddr;
            wd_hold <= wdata;
            st      <= W_PRD;
          end
        end
        W_PRD: begin
          re <= 1'b0;
          st <= W_PCAP;
        end
        W_PCAP: begin
          we      <= 1'b1;
          wdata_o <= mem_rdata & wd_hold;
          st      <= W_PWR;
        end
        W_PWR: begin
          we <= 1'b0;
          st <= W_IDLE;
        end
        W_ERASE: begin
          if (idx == BI_W'(BLK_WORDS - 1)) begin
            we <= 1'b0;
            st <= W_IDLE;
          end else begin
            idx  <= idx + BI_W'(1);
            addr <= addr + WA_W'(1);
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int FLASH_BYTES  = 131072,
  parameter int WORD_BYTES   = 4,
  parameter int ERASE_BYTES  = 1024,
  parameter int REGION_BYTES = 2048,
  parameter int PROG_CYC     = 6,
  parameter int ERASE_TAIL   = 4,
  localparam int ADDR_W    = $clog2(FLASH_BYTES),
  localparam int DW        = 8 * WORD_BYTES,
  localparam int WOFF      = $clog2(WORD_BYTES),
  localparam int WA_W      = ADDR_W - WOFF,
  localparam int BLK_WORDS = ERASE_BYTES / WORD_BYTES,
  localparam int RSH       = $clog2(REGION_BYTES),
  localparam int NREG      = FLASH_BYTES / REGION_BYTES,
  localparam int RIDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_dbg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              acc_err,
  output logic              busy,
  input  logic              prot_we,
  input  logic [RIDX_W-1:0] prot_region,
  input  logic [1:0]        prot_mode,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);

  logic              accept, allow, rd_issue, wr_req, wr_start, wr_blk;
  logic              wr_err_q, rd_err;
  logic [1:0]        look_mode;
  logic [2*NREG-1:0] mode_tbl;
  logic [WA_W-1:0]   waddr, rp_addr, eng_addr;
  logic              rp_re, eng_re;
  logic              unused_lsb;

  assign waddr      = req_addr[ADDR_W-1:WOFF];
  assign unused_lsb = ^req_addr[WOFF-1:0];

  assign accept   = req_valid & ~busy;
  assign rd_issue = accept & ~req_op[1];
  assign wr_req   = accept &  req_op[1];
  assign wr_start = wr_req &  allow;
  assign wr_blk   = wr_req & ~allow;

  fg_region_table #(.NREG(NREG), .RIDX_W(RIDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (prot_we),
    .upd_idx   (prot_region),
    .upd_mode  (prot_mode),
    .look_idx  (req_addr[ADDR_W-1:RSH]),
    .look_mode (look_mode),
    .tbl_flat  (mode_tbl)
  );

  fg_policy u_policy (
    .op    (req_op),
    .dbg   (req_dbg),
    .mode  (look_mode),
    .allow (allow)
  );

  fg_read_pipe #(.WA_W(WA_W), .DW(DW)) u_rpipe (
    .clk       (clk),
    .rst       (rst),
    .issue     (rd_issue),
    .allow     (allow),
    .waddr     (waddr),
    .mem_rdata (mem_rdata),
    .re        (rp_re),
    .raddr     (rp_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata),
    .rd_err    (rd_err)
  );

  fg_write_engine #(
    .WA_W(WA_W), .DW(DW), .BLK_WORDS(BLK_WORDS),
    .PROG_CYC(PROG_CYC), .ERASE_TAIL(ERASE_TAIL)
  ) u_weng (
    .clk       (clk),
    .rst       (rst),
    .start     (wr_start),
    .is_erase  (req_op[0]),
    .waddr     (waddr),
    .wdata     (req_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .re        (eng_re),
    .we        (mem_we),
    .addr      (eng_addr),
    .wdata_o   (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_err_q <= 1'b0;
    else     wr_err_q <= wr_blk;
  end

  assign acc_err   = wr_err_q | rd_err;
  assign req_ready = ~busy;
  assign mem_re    = rp_re | eng_re;
  assign mem_addr  = rp_re ? rp_addr : eng_addr;

endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int NREG   = 64,
  parameter int ADDR_W = 17,
  parameter int RSH    = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              mem_re,
  input logic              mem_we,
  input logic              rsp_valid,
  input logic              rd_issue,
  input logic              wr_start,
  input logic [2*NREG-1:0] mode_tbl
);

  function automatic logic [1:0] rank_of(input logic [1:0] m);
    return (m == 2'b00) ? 2'd0 : (m == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  logic [1:0] m_now;
  assign m_now = mode_tbl[2*int'(req_addr[ADDR_W-1:RSH]) +: 2];

  // R4: the array port is never read and written in one cycle
  p_port_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R4: nothing is accepted while busy
  p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(rd_issue || wr_start));

  // R4: an accepted program or erase raises busy next cycle
  p_busy_start_r4: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> busy);

  // R1: every response follows a read accepted three cycles earlier
  p_rsp_latency_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_issue, 3));

  // R6 / R8: a modifying operation only starts in an open region
  p_start_open_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(m_now) == 2'b00));

  // R9: region strictness never decreases outside reset
  for (genvar g = 0; g < NREG; g++) begin : g_mono
    p_tighten_only_r9: assert property (@(posedge clk) disable iff (rst)
      rank_of(mode_tbl[2*g +: 2]) >= rank_of($past(mode_tbl[2*g +: 2])));
  end

endmodule

bind flash_guard fg_checker u_fg_checker (.*);

// File: tb/flash_guard_bench.sv
module flash_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 6;
  localparam int ERASE_TAIL = 4;
  localparam int BLK_WORDS  = 256;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic        req_dbg = 1'b0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        acc_err;
  logic        busy;
  logic        prot_we = 1'b0;
  logic [5:0]  prot_region = '0;
  logic [1:0]  prot_mode = '0;
  logic        mem_re, mem_we;
  logic [14:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard #(.PROG_CYC(PROG_CYC), .ERASE_TAIL(ERASE_TAIL)) u_flash_guard (
    .clk, .rst, .req_valid, .req_ready, .req_op, .req_dbg, .req_addr,
    .req_wdata, .rsp_valid, .rsp_rdata, .acc_err, .busy, .prot_we,
    .prot_region, .prot_mode, .mem_re, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata
  );

  // behavioural flash array (unwritten words read as erased)
  logic [31:0] dev_mem [int];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 32'hFFFF_FFFF;
    if (mem_we) dev_mem[int'(mem_addr)] = mem_wdata;
  end

  // reference model
  logic [31:0] ref_mem [int];
  logic [31:0] exp_rsp [int];
  bit          exp_err [int];
  int          ref_tbl [64];
  int          busy_end = -1;
  int          cyc = 0;
  bit          seen_rst = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic int rank_of(input int m);
    return (m == 0) ? 0 : (m == 1) ? 1 : 2;
  endfunction

  function automatic logic [31:0] ref_rd(input int w);
    return ref_mem.exists(w) ? ref_mem[w] : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (ref_tbl[i]) ref_tbl[i] = 0;
      busy_end = -1;
      exp_rsp.delete();
      exp_err.delete();
      seen_rst = 1;
    end else begin
      if (req_valid && !(cyc <= busy_end)) begin
        int r, m, w;
        bit ok;
        r = int'(req_addr[16:11]);
        m = ref_tbl[r];
        w = int'(req_addr[16:2]);
        if (req_op[1] == 1'b0) begin
          ok = (m != 2) || (req_op == 2'b01 && !req_dbg);
          exp_rsp[cyc + 3] = ok ? ref_rd(w) : 32'h0;
          if (!ok) exp_err[cyc + 3] = 1;
        end else if (m != 0) begin
          exp_err[cyc + 1] = 1;
        end else if (req_op == 2'b10) begin
          ref_mem[w] = ref_rd(w) & req_wdata;
          busy_end = cyc + PROG_CYC;
        end else begin
          for (int k = 0; k < BLK_WORDS; k++) ref_mem[(w & ~(BLK_WORDS-1)) + k] = 32'hFFFF_FFFF;
          busy_end = cyc + BLK_WORDS + ERASE_TAIL;
        end
      end
      if (prot_we && rank_of(int'(prot_mode)) > rank_of(ref_tbl[prot_region]))
        ref_tbl[prot_region] = (prot_mode == 2'b11) ? 2 : int'(prot_mode);
    end
    cyc++;
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", what, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (seen_rst && !done) begin
      bit          e_v, e_e, e_b;
      logic [31:0] e_d;
      e_v = exp_rsp.exists(cyc);
      e_d = e_v ? exp_rsp[cyc] : 32'h0;
      e_e = exp_err.exists(cyc);
      e_b = (cyc <= busy_end);
      check(rsp_valid == e_v, "R1/R7 rsp_valid", 32'(rsp_valid), 32'(e_v));
      check(rsp_rdata == e_d, "R1/R2/R3/R7 rsp_rdata", rsp_rdata, e_d);
      check(acc_err == e_e, "R6/R8/R11 acc_err", 32'(acc_err), 32'(e_e));
      check(busy == e_b, "R4 busy", 32'(busy), 32'(e_b));
      check(req_ready == !e_b, "R4 req_ready", 32'(req_ready), 32'(!e_b));
      if (e_v) exp_rsp.delete(cyc);
      if (e_e) exp_err.delete(cyc);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // stimulus helpers: drive at negedge; accepted at the next posedge when not busy
  task automatic issue(input logic [1:0] op, input bit dbg, input int addr, input logic [31:0] wd);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_op = op; req_dbg = dbg; req_addr = 17'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_dbg = 0;
  endtask

  task automatic issue_early(input logic [1:0] op, input int addr);
    @(negedge clk);
    req_valid = 1; req_op = op; req_dbg = 0; req_addr = 17'(addr); req_wdata = '1;
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic set_mode(input int r, input logic [1:0] m);
    @(negedge clk);
    prot_we = 1; prot_region = 6'(r); prot_mode = m;
    @(negedge clk);
    prot_we = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      dev_mem[i] = 32'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
      ref_mem[i] = dev_mem[i];
    end
    repeat (3) @(negedge clk);
    // R10: idle outputs after reset
    check(busy == 0 && req_ready == 1 && rsp_valid == 0 && acc_err == 0,
          "R10 reset state", {busy, req_ready, rsp_valid, acc_err}, 32'h4);
    rst = 0;
    settle();

    // R1: reads and fetches in open regions, including back-to-back
    issue(2'b00, 0, 32'h0000, 0);
    issue(2'b01, 0, 32'h0010, 0);
    issue(2'b00, 0, 32'h0FFC, 0);
    @(negedge clk);
    req_valid = 1; req_op = 2'b00;
    for (int k = 0; k < 4; k++) begin
      req_addr = 17'(32'h0100 + 4*k);
      @(negedge clk);
    end
    req_valid = 0;
    settle();

    // R3: program clears bits only; a second program cannot restore ones
    issue(2'b10, 0, 32'h0800, 32'hF0F0_FFFF);
    issue(2'b10, 0, 32'h0800, 32'h0FFF_0F0F);
    issue(2'b00, 0, 32'h0800, 0);
    issue(2'b10, 0, 32'h9000, 32'h1234_5678);
    issue(2'b00, 0, 32'h9000, 0);
    settle();

    // R2: erase block 4; neighbours in blocks 3 and 5 keep their data
    issue(2'b11, 0, 32'h1040, 0);
    issue(2'b00, 0, 32'h1000, 0);
    issue(2'b00, 0, 32'h13FC, 0);
    issue(2'b00, 0, 32'h0FFC, 0);
    issue(2'b00, 0, 32'h1400, 0);
    settle();

    // R4: a request raised during busy waits for busy to fall
    issue(2'b11, 0, 32'h1400, 0);
    issue_early(2'b00, 32'h1404);
    issue(2'b10, 0, 32'h0804, 32'h0);
    issue_early(2'b10, 32'h0808);
    settle();

    // R6: read-only region 3 refuses program and erase, allows reads
    issue(2'b10, 0, 32'h2000, 32'h1234_5678);
    set_mode(3, 2'b01);
    issue(2'b10, 0, 32'h1800, 32'h0);
    issue(2'b11, 0, 32'h1800, 0);
    issue(2'b00, 0, 32'h1800, 0);
    issue(2'b01, 0, 32'h1FFC, 0);
    // R11: two refused writes back to back give two pulses
    @(negedge clk);
    req_valid = 1; req_op = 2'b10; req_addr = 17'h1804; req_wdata = 0;
    @(negedge clk);
    req_addr = 17'h1808;
    @(negedge clk);
    req_valid = 0;
    settle();

    // R7 / R8: execute-only region 4
    set_mode(4, 2'b10);
    issue(2'b01, 0, 32'h2000, 0);
    issue(2'b00, 0, 32'h2000, 0);
    issue(2'b00, 1, 32'h2004, 0);
    issue(2'b01, 1, 32'h2000, 0);
    issue(2'b10, 0, 32'h2000, 32'h0);
    issue(2'b11, 0, 32'h2400, 0);
    issue(2'b01, 0, 32'h2000, 0);
    settle();

    // R5 / R9: code 11 acts as execute-only; relaxing writes are ignored
    set_mode(5, 2'b11);
    issue(2'b00, 0, 32'h2800, 0);
    set_mode(5, 2'b01);
    issue(2'b00, 0, 32'h2FFC, 0);
    issue(2'b00, 0, 32'h3000, 0);
    set_mode(3, 2'b00);
    issue(2'b10, 0, 32'h1800, 32'h0);
    set_mode(3, 2'b10);
    issue(2'b00, 0, 32'h1800, 0);
    issue(2'b01, 0, 32'h1800, 0);
    set_mode(63, 2'b01);
    issue(2'b10, 0, 32'h1FFFC, 32'h0);
    issue(2'b10, 0, 32'h1F7FC, 32'hFF00_FF00);
    issue(2'b00, 0, 32'h1F7FC, 0);
    settle();

    // R10: reset relaxes every region
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    issue(2'b10, 0, 32'h2000, 32'h0000_FFFF);
    issue(2'b00, 0, 32'h2000, 0);
    issue(2'b00, 0, 32'h2800, 0);
    issue(2'b11, 0, 32'h1800, 0);
    issue(2'b00, 0, 32'h1BFC, 0);
    settle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule